// File: doc/BRIEF.md
# GPIO Bank with Per-Line Interrupt Sensing

This block controls one bank of up to 32 general-purpose lines behind a 32-bit register interface with select, write, address, write-data and read-data signals. Each line is a plain input, a plain output or an interrupt input. Bit n of every register belongs to line n. A write takes effect on the clock edge where select and write are both high. A read is combinational from the address.

Pin levels first pass an input-enable gate and then a two-flop synchronizer. The synchronized level is what the input-data register shows, and it also feeds the interrupt detector. For each interrupt line software picks polarity, edge or level sensing, and single-edge or both-edge detection. Latched edge status is cleared by writing ones. The enable mask is opened through a separate set register and closed through zeros written to the mask register. One interrupt output is the OR over all lines of status ANDed with mask.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset every register reads 0, `pin_oe`, `pin_out` and `irq` are 0, and the write-only addresses 0x14 and 0x1C always read 0.
- R2: `pin_out` equals the output-data register at 0x08. A line's bit in `pin_oe` is 1 exactly when its direction bit (0x04, 1 = output) is 1 and its mode bit (0x00, 1 = interrupt input) is 0.
- R3: Address 0x0C returns the pin level two clock edges after it is applied, for input and output lines alike. A line whose input-enable bit (0x50) is 0 reads 0.
- R4: An interrupt line with edge bit (0x24) 1, polarity bit (0x20) 0 and both-edge bit (0x4C) 0 sets its status bit (0x10) on a rising edge and keeps it. A falling edge does not set it.
- R5: With polarity 1 and both-edge 0, an edge-mode line sets status on a falling edge only.
- R6: With both-edge 1, an edge-mode line sets status on rising and falling edges.
- R7: Writing 1 to a bit of 0x14 clears that edge-mode line's status. Bits written as 0 leave status unchanged.
- R8: A level-mode interrupt line (edge bit 0) has a status equal to the pin level XOR its polarity bit, tracking the pin live. Writes to 0x14 do not affect it.
- R9: Writing 1 to a bit of 0x1C sets that mask bit. A write to 0x18 clears the mask bits written as 0 and keeps those written as 1. Reading 0x18 returns the mask.
- R10: `irq` is 1 exactly when some line has both status and mask bits set.
- R11: A line in general I/O mode never holds a status bit, whatever its pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register access select |
| pwrite | input | 1 | Write strobe, qualified by psel |
| paddr | input | 8 | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for paddr |
| pin_in | input | LINES | Pin levels from the pads |
| pin_out | output | LINES | Output data per line |
| pin_oe | output | LINES | Output enable per line |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench checks that a falling edge on a rising-edge line is ignored and that a rising edge on a falling-edge line is ignored. A detector that compared the wrong edge direction, or ignored polarity, would set status on the wrong transition. It writes zeros to the clear register while an edge is latched, and writes the clear register while a level line is active. A design that cleared every bit on any write, or let clear act on level lines, would lose status that should remain. It writes the mask register with a mostly-ones pattern, so a design that stored the value instead of ANDing it in would show the wrong mask. It also toggles a line in general I/O mode and checks that the line's status stays 0 and `irq` stays low.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_MODE   = 8'h00;
  localparam addr_t A_DIR    = 8'h04;
  localparam addr_t A_DOUT   = 8'h08;
  localparam addr_t A_DIN    = 8'h0C;
  localparam addr_t A_STAT   = 8'h10;
  localparam addr_t A_CLR    = 8'h14;
  localparam addr_t A_MASK   = 8'h18;
  localparam addr_t A_MSKSET = 8'h1C;
  localparam addr_t A_POL    = 8'h20;
  localparam addr_t A_EDGE   = 8'h24;
  localparam addr_t A_BOTH   = 8'h4C;
  localparam addr_t A_INEN   = 8'h50;
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/gpb_line.sv
module gpb_line (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic irq_mode_i,
  input  logic edge_i,
  input  logic pol_i,
  input  logic both_i,
  input  logic clr_i,
  output logic stat_o
);
  logic prev_q;
  logic stat_q;
  logic stat_d;
  logic rise;
  logic fall;
  logic hit;

  always_comb begin
    rise = lvl_i & ~prev_q;
    fall = ~lvl_i & prev_q;
    if (both_i) hit = rise | fall;
    else        hit = pol_i ? fall : rise;

    if (!irq_mode_i)  stat_d = 1'b0;
    else if (!edge_i) stat_d = lvl_i ^ pol_i;
    else              stat_d = hit | (stat_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
  import gpb_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             pwrite,
  input  addr_t            paddr,
  input  logic [BUS_W-1:0] pwdata,
  input  logic [LINES-1:0] lvl_i,
  input  logic [LINES-1:0] stat_i,
  output logic [BUS_W-1:0] prdata,
  output logic [LINES-1:0] mode_o,
  output logic [LINES-1:0] dir_o,
  output logic [LINES-1:0] dout_o,
  output logic [LINES-1:0] mask_o,
  output logic [LINES-1:0] pol_o,
  output logic [LINES-1:0] edge_o,
  output logic [LINES-1:0] both_o,
  output logic [LINES-1:0] inen_o,
  output logic [LINES-1:0] clr_o
);
  logic             wr;
  logic [LINES-1:0] wbits;
  logic [LINES-1:0] mode_q, dir_q, dout_q, mask_q, pol_q, edge_q, both_q, inen_q;
  logic [LINES-1:0] mode_d, dir_d, dout_d, mask_d, pol_d, edge_d, both_d, inen_d;
  logic [LINES-1:0] rd;

  assign wr    = psel & pwrite;
  assign wbits = pwdata[LINES-1:0];

  always_comb begin
    mode_d = mode_q;
    dir_d  = dir_q;
    dout_d = dout_q;
    mask_d = mask_q;
    pol_d  = pol_q;
    edge_d = edge_q;
    both_d = both_q;
    inen_d = inen_q;
    clr_o  = '0;
    if (wr) begin
      case (paddr)
        A_MODE:   mode_d = wbits;
        A_DIR:    dir_d  = wbits;
        A_DOUT:   dout_d = wbits;
        A_CLR:    clr_o  = wbits;
        A_MASK:   mask_d = mask_q & wbits;
        A_MSKSET: mask_d = mask_q | wbits;
        A_POL:    pol_d  = wbits;
        A_EDGE:   edge_d = wbits;
        A_BOTH:   both_d = wbits;
        A_INEN:   inen_d = wbits;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      dout_q <= '0;
      mask_q <= '0;
      pol_q  <= '0;
      edge_q <= '0;
      both_q <= '0;
      inen_q <= '0;
    end else begin
      mode_q <= mode_d;
      dir_q  <= dir_d;
      dout_q <= dout_d;
      mask_q <= mask_d;
      pol_q  <= pol_d;
      edge_q <= edge_d;
      both_q <= both_d;
      inen_q <= inen_d;
    end
  end

  always_comb begin
    case (paddr)
      A_MODE:  rd = mode_q;
      A_DIR:   rd = dir_q;
      A_DOUT:  rd = dout_q;
      A_DIN:   rd = lvl_i;
      A_STAT:  rd = stat_i;
      A_MASK:  rd = mask_q;
      A_POL:   rd = pol_q;
      A_EDGE:  rd = edge_q;
      A_BOTH:  rd = both_q;
      A_INEN:  rd = inen_q;
      default: rd = '0;
    endcase
    prdata = '0;
    prdata[LINES-1:0] = rd;
  end

  assign mode_o = mode_q;
  assign dir_o  = dir_q;
  assign dout_o = dout_q;
  assign mask_o = mask_q;
  assign pol_o  = pol_q;
  assign edge_o = edge_q;
  assign both_o = both_q;
  assign inen_o = inen_q;
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             pwrite,
  input  logic [7:0]       paddr,
  input  logic [31:0]      pwdata,
  output logic [31:0]      prdata,
  input  logic [LINES-1:0] pin_in,
  output logic [LINES-1:0] pin_out,
  output logic [LINES-1:0] pin_oe,
  output logic             irq
);
  logic [LINES-1:0] mode_q, dir_q, dout_q, mask_q, pol_q, edge_q, both_q, inen_q;
  logic [LINES-1:0] clr_pulse;
  logic [LINES-1:0] lvl_s;
  logic [LINES-1:0] stat_q;

  gpb_regs #(.LINES(LINES)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .psel   (psel),
    .pwrite (pwrite),
    .paddr  (paddr),
    .pwdata (pwdata),
    .lvl_i  (lvl_s),
    .stat_i (stat_q),
    .prdata (prdata),
    .mode_o (mode_q),
    .dir_o  (dir_q),
    .dout_o (dout_q),
    .mask_o (mask_q),
    .pol_o  (pol_q),
    .edge_o (edge_q),
    .both_o (both_q),
    .inen_o (inen_q),
    .clr_o  (clr_pulse)
  );

  gpb_sync #(.W(LINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_in & inen_q),
    .q_o   (lvl_s)
  );

  for (genvar n = 0; n < LINES; n++) begin : g_line
    gpb_line u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_i      (lvl_s[n]),
      .irq_mode_i (mode_q[n]),
      .edge_i     (edge_q[n]),
      .pol_i      (pol_q[n]),
      .both_i     (both_q[n]),
      .clr_i      (clr_pulse[n]),
      .stat_o     (stat_q[n])
    );
  end

  assign pin_out = dout_q;
  assign pin_oe  = ~mode_q & dir_q;
  assign irq     = |(stat_q & mask_q);
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker
  import gpb_pkg::*;
#(
  parameter int LINES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             psel,
  input logic             pwrite,
  input logic [7:0]       paddr,
  input logic [31:0]      pwdata,
  input logic [LINES-1:0] pin_oe,
  input logic             irq,
  input logic [LINES-1:0] mode,
  input logic [LINES-1:0] edge_sel,
  input logic [LINES-1:0] pol,
  input logic [LINES-1:0] lvl,
  input logic [LINES-1:0] stat,
  input logic [LINES-1:0] mask
);
  logic             wr;
  logic [LINES-1:0] clr_bits;
  logic             mask_wr;

  always_comb begin
    wr       = psel & pwrite;
    clr_bits = (wr && paddr == A_CLR) ? pwdata[LINES-1:0] : '0;
    mask_wr  = wr && (paddr == A_MASK || paddr == A_MSKSET);
  end

  // R2: a line in interrupt mode never drives
  a_r2_no_drive_in_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & mode) == '0);

  // R4 / R7: latched edge status only drops after a clear write
  a_r7_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat) & ~stat) & $past(mode & edge_sel) & ~$past(clr_bits)) == '0));

  // R8: level lines track the qualified level
  a_r8_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((stat ^ $past(lvl ^ pol)) & $past(mode & ~edge_sel)) == '0));

  // R9: mask only changes through its two write addresses
  a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask));

  // R10: nothing enabled means no interrupt
  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

  // R11: general I/O lines hold no status
  a_r11_gpio_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(mode)) == '0));
endmodule

bind gpio_bank_irq gpb_checker #(.LINES(LINES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .psel     (psel),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .pwdata   (pwdata),
  .pin_oe   (pin_oe),
  .irq      (irq),
  .mode     (mode_q),
  .edge_sel (edge_q),
  .pol      (pol_q),
  .lvl      (lvl_s),
  .stat     (stat_q),
  .mask     (mask_q)
);

// File: tb/tb_gpio_bank_irq.sv
module tb_gpio_bank_irq;
  localparam int CLK_T = 10;
  localparam int LINES = 32;

  logic             clk;
  logic             rst_n;
  logic             psel;
  logic             pwrite;
  logic [7:0]       paddr;
  logic [31:0]      pwdata;
  logic [31:0]      prdata;
  logic [LINES-1:0] pin_in;
  logic [LINES-1:0] pin_out;
  logic [LINES-1:0] pin_oe;
  logic             irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  gpio_bank_irq #(.LINES(LINES)) dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_T/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    psel = 1'b0; pwrite = 1'b0; pwdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    paddr = a;
    #1 d = prdata;
  endtask

  task automatic settle(input logic [LINES-1:0] p);
    @(negedge clk);
    pin_in = p;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 'h54; a += 4) begin
      rd(a[7:0], v);
      chk("R1 register reset", v, 32'h0);
    end
    chk("R1 oe reset", pin_oe, '0);
    chk("R1 out reset", pin_out, '0);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_output;
    wr(8'h04, 32'h0000_00F0);
    wr(8'h08, 32'h0000_00A5);
    @(negedge clk);
    chk("R2 oe from direction", pin_oe, 32'h0000_00F0);
    chk("R2 pin_out", pin_out, 32'h0000_00A5);
    wr(8'h00, 32'h0000_0010);
    @(negedge clk);
    chk("R2 interrupt mode drops oe", pin_oe, 32'h0000_00E0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_input;
    logic [31:0] v;
    wr(8'h50, 32'h0000_FFFF);
    @(negedge clk);
    pin_in = 32'h1234_5678;
    @(negedge clk);
    rd(8'h0C, v);
    chk("R3 input after two edges", v, 32'h0000_5678);
    rd(8'h0C, v);
    chk("R3 disabled lines read 0", v, 32'h0000_5678);
    wr(8'h50, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    rd(8'h0C, v);
    chk("R3 all enabled incl output lines", v, 32'h1234_5678);
    wr(8'h04, 32'h0);
    settle(32'h0);
  endtask

  task automatic t_setup_irq;
    logic [31:0] v;
    wr(8'h00, 32'h0000_000F);
    wr(8'h24, 32'h0000_0007);
    wr(8'h20, 32'h0000_0002);
    wr(8'h4C, 32'h0000_0004);
    wr(8'h1C, 32'h0000_000F);
    repeat (4) @(negedge clk);
    rd(8'h10, v);
    chk("R4 quiet after config", v, 32'h0);
    rd(8'h18, v);
    chk("R9 mask set via 0x1C", v, 32'h0000_000F);
  endtask

  task automatic t_rise;
    logic [31:0] v;
    settle(32'h1);
    rd(8'h10, v);
    chk("R4 rising latches", v, 32'h1);
    chk("R10 irq on pending", {31'b0, irq}, 32'h1);
    settle(32'h0);
    rd(8'h10, v);
    chk("R4 falling keeps latch", v, 32'h1);
    wr(8'h14, 32'h0);
    rd(8'h10, v);
    chk("R7 zero clear no effect", v, 32'h1);
    wr(8'h14, 32'h1);
    rd(8'h10, v);
    chk("R7 one clears", v, 32'h0);
    chk("R10 irq drops", {31'b0, irq}, 32'h0);
    rd(8'h14, v);
    chk("R1 clear reads 0", v, 32'h0);
    settle(32'h1);
    wr(8'h14, 32'h1);
    settle(32'h0);
    rd(8'h10, v);
    chk("R4 falling ignored", v, 32'h0);
  endtask

  task automatic t_fall;
    logic [31:0] v;
    settle(32'h2);
    rd(8'h10, v);
    chk("R5 rising ignored", v, 32'h0);
    settle(32'h0);
    rd(8'h10, v);
    chk("R5 falling latches", v, 32'h2);
    wr(8'h14, 32'h2);
  endtask

  task automatic t_both;
    logic [31:0] v;
    settle(32'h4);
    rd(8'h10, v);
    chk("R6 rising latches", v, 32'h4);
    wr(8'h14, 32'h4);
    settle(32'h0);
    rd(8'h10, v);
    chk("R6 falling latches", v, 32'h4);
    wr(8'h14, 32'h4);
    rd(8'h10, v);
    chk("R6 cleared", v, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    settle(32'h8);
    rd(8'h10, v);
    chk("R8 level high", v, 32'h8);
    wr(8'h14, 32'h8);
    rd(8'h10, v);
    chk("R8 clear ignored", v, 32'h8);
    settle(32'h0);
    rd(8'h10, v);
    chk("R8 follows low", v, 32'h0);
    wr(8'h20, 32'h0000_000A);
    repeat (3) @(negedge clk);
    rd(8'h10, v);
    chk("R8 active-low level", v, 32'h8);
    wr(8'h20, 32'h0000_0002);
    repeat (3) @(negedge clk);
    rd(8'h10, v);
    chk("R8 back to quiet", v, 32'h0);
  endtask

  task automatic t_gpio;
    logic [31:0] v;
    settle(32'h20);
    rd(8'h10, v);
    chk("R11 gpio line no status", v, 32'h0);
    rd(8'h0C, v);
    chk("R3 gpio line level", v, 32'h20);
    settle(32'h0);
    rd(8'h10, v);
    chk("R11 gpio line after fall", v, 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(8'h18, 32'hFFFF_FFF5);
    rd(8'h18, v);
    chk("R9 zeros clear ones keep", v, 32'h5);
    settle(32'h8);
    rd(8'h10, v);
    chk("R10 status while masked", v, 32'h8);
    chk("R10 masked irq low", {31'b0, irq}, 32'h0);
    wr(8'h1C, 32'h8);
    rd(8'h18, v);
    chk("R9 set adds bit", v, 32'hD);
    chk("R10 unmasked irq high", {31'b0, irq}, 32'h1);
    rd(8'h1C, v);
    chk("R1 mask-set reads 0", v, 32'h0);
    settle(32'h0);
    chk("R10 irq follows level", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    #(CLK_T * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; psel = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_output();
    t_input();
    t_setup_irq();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_gpio();
    t_mask();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule